// File: doc/BRIEF.md
# Posted-Write Dualcast Address Matcher

This block sits on the ingress side of one port of a packet switch. For each transaction header it accepts, it issues the header unchanged as a routing request to the port that the ordinary address decoder picked. It then decides whether the header also needs a duplicate. A small bank of programmable address windows makes that decision. Each window holds a base, an inclusive limit, a translation offset, a target egress port and an enable flag.

When a posted write lands inside an enabled window, the block issues a second routing request on the next cycle. That copy carries a rewritten address, which is the original address minus the window base plus the window's translation value. The copy is steered to the window's target port. In every other respect it matches the original, so the receiving endpoint cannot distinguish it from ordinary unicast traffic. The input side stalls for exactly that one extra cycle. A status counter records each copy whose target equals the original's routed port. All control sits in the block's own configuration registers.

Top module: `dualcast_matcher`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `same_port_cnt` is 0 and every window is disabled.
- R2: A header accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs after that edge, with `out_copy`=0 and `out_addr`, `out_kind`, `out_tag` and `out_port` equal to the accepted `in_addr`, `in_kind`, `in_tag` and `in_port`.
- R3: A posted write (`in_kind`=0) whose address satisfies base <= address <= limit for an enabled window produces, on the cycle after its original, a copy with `out_copy`=1. The copy carries the same kind and tag, the window's target port, and the address address - base + translation.
- R4: Non-posted requests (`in_kind`=1) and completions (`in_kind`=2) never produce a copy, even when their address falls inside an enabled window.
- R5: A disabled window never produces a copy.
- R6: When several enabled windows contain the address, only the lowest-numbered one is used, and exactly one copy is issued.
- R7: While a copy is pending, `in_ready` is 0 for exactly that one cycle. A header held on the input is accepted only after the copy has been issued.
- R8: A copy whose target port equals the original's `in_port` is still issued, and `same_port_cnt` increments by one on the edge that issues it.
- R9: A configuration write (`cfg_we`=1) updates window `cfg_win` at the next edge, according to `cfg_field`. Code 0 writes the base, 1 the limit, 2 the translation offset, and 3 the control word, where bit 0 is the enable and bits 3:1 are the target port. A header accepted on the same edge still sees the old settings.
- R10: The translated address is computed modulo 2^64, so sums that overflow wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window selected by the write |
| cfg_field | input | 2 | Register selected: 0 base, 1 limit, 2 translation, 3 control |
| cfg_wdata | input | 64 | Write data |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be taken this cycle |
| in_kind | input | 2 | 0 posted write, 1 non-posted, 2 completion |
| in_addr | input | 64 | Header address |
| in_tag | input | 8 | Other header content, carried through |
| in_port | input | 3 | Port chosen by ordinary address routing |
| out_valid | output | 1 | Routing request valid |
| out_copy | output | 1 | Request is the duplicate |
| out_kind | output | 2 | Kind of the request |
| out_addr | output | 64 | Address of the request |
| out_tag | output | 8 | Carried header content |
| out_port | output | 3 | Destination egress port |
| same_port_cnt | output | 16 | Copies whose target equalled the routed port |

## Verification
A corrupted window register or a wrong priority choice shows up on the very next request that touches that window. The symptom is a missing or extra copy, or a copy with a wrong address or port, one cycle after the original. A stuck pending flag shows up at once as `in_ready` staying low or never dropping. The bench therefore compares every output against a behavioural model on every clock, and it places addresses on the inclusive edges of each window, on overlapping windows and at the top of the address space.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

   // Transaction kinds presented on the ingress header
   typedef enum logic [1:0] {
      KIND_POSTED  = 2'd0,
      KIND_NONPOST = 2'd1,
      KIND_CPL     = 2'd2,
      KIND_RSVD    = 2'd3
   } dcm_kind_e;

   // Configuration register selector
   typedef enum logic [1:0] {
      FLD_BASE  = 2'd0,
      FLD_LIMIT = 2'd1,
      FLD_XLAT  = 2'd2,
      FLD_CTRL  = 2'd3
   } dcm_field_e;

   // Control word layout: enable in bit 0, target port above it
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_PORT_LSB = 1;

endpackage

// File: rtl/dcm_window_bank.sv
module dcm_window_bank
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NWIN   = 4,
   parameter int PORT_W = 3,
   localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WIN_W-1:0]  cfg_win,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] win_base  [NWIN],
   output logic [ADDR_W-1:0] win_limit [NWIN],
   output logic [ADDR_W-1:0] win_xlat  [NWIN],
   output logic [PORT_W-1:0] win_port  [NWIN],
   output logic              win_en    [NWIN]
);

   // One register set per window
   for (genvar g = 0; g < NWIN; g++) begin : g_win
      logic sel;
      assign sel = cfg_we && (cfg_win == WIN_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_base[g]  <= '0;
            win_limit[g] <= '0;
            win_xlat[g]  <= '0;
            win_port[g]  <= '0;
            win_en[g]    <= 1'b0;
         end else if (sel) begin
            unique case (dcm_field_e'(cfg_field))
               FLD_BASE:  win_base[g]  <= cfg_wdata;
               FLD_LIMIT: win_limit[g] <= cfg_wdata;
               FLD_XLAT:  win_xlat[g]  <= cfg_wdata;
               FLD_CTRL: begin
                  win_en[g]   <= cfg_wdata[CTRL_EN_BIT];
                  win_port[g] <= cfg_wdata[CTRL_PORT_LSB +: PORT_W];
               end
               default: ;
            endcase
         end
      end

      // R1: a window leaves reset disabled
      // R1
      win_reset_off_chk: assert property (@(posedge clk)
         $rose(rst_n) |-> !win_en[g]);
   end

endmodule

// File: rtl/dcm_match.sv
module dcm_match
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NWIN   = 4,
   parameter int PORT_W = 3,
   localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] win_base  [NWIN],
   input  logic [ADDR_W-1:0] win_limit [NWIN],
   input  logic [ADDR_W-1:0] win_xlat  [NWIN],
   input  logic [PORT_W-1:0] win_port  [NWIN],
   input  logic              win_en    [NWIN],
   output logic              dup_hit,
   output logic [ADDR_W-1:0] dup_addr,
   output logic [PORT_W-1:0] dup_port
);

   logic [NWIN-1:0]  w_hit;
   logic [WIN_W-1:0] sel;

   // Per-window inclusive range compare
   for (genvar g = 0; g < NWIN; g++) begin : g_cmp
      assign w_hit[g] = win_en[g]
                     && (addr >= win_base[g])
                     && (addr <= win_limit[g]);
   end

   // Lowest index has priority: scan from the top down
   always_comb begin
      sel = '0;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (w_hit[i]) sel = WIN_W'(i);
      end
   end

   assign dup_hit  = (|w_hit) && (dcm_kind_e'(kind) == KIND_POSTED);
   assign dup_addr = addr - win_base[sel] + win_xlat[sel];
   assign dup_port = win_port[sel];

endmodule

// File: rtl/dcm_issue.sv
module dcm_issue
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PORT_W = 3,
   parameter int TAG_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [PORT_W-1:0] in_port,
   input  logic              dup_hit,
   input  logic [ADDR_W-1:0] dup_addr,
   input  logic [PORT_W-1:0] dup_port,
   output logic              out_valid,
   output logic              out_copy,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TAG_W-1:0]  out_tag,
   output logic [PORT_W-1:0] out_port,
   output logic [CNT_W-1:0]  same_port_cnt
);

   logic              pend;
   logic [ADDR_W-1:0] cp_addr;
   logic [PORT_W-1:0] cp_port;
   logic [PORT_W-1:0] orig_port;
   logic              accept;

   assign in_ready = !pend;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend          <= 1'b0;
         cp_addr       <= '0;
         cp_port       <= '0;
         orig_port     <= '0;
         out_valid     <= 1'b0;
         out_copy      <= 1'b0;
         out_kind      <= '0;
         out_addr      <= '0;
         out_tag       <= '0;
         out_port      <= '0;
         same_port_cnt <= '0;
      end else if (pend) begin
         // Second request: kind and tag still held from the original
         pend      <= 1'b0;
         out_valid <= 1'b1;
         out_copy  <= 1'b1;
         out_addr  <= cp_addr;
         out_port  <= cp_port;
         if (cp_port == orig_port) same_port_cnt <= same_port_cnt + 1'b1;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_copy  <= 1'b0;
         out_kind  <= in_kind;
         out_addr  <= in_addr;
         out_tag   <= in_tag;
         out_port  <= in_port;
         pend      <= dup_hit;
         cp_addr   <= dup_addr;
         cp_port   <= dup_port;
         orig_port <= in_port;
      end else begin
         out_valid <= 1'b0;
         out_copy  <= 1'b0;
      end
   end

   // R2
   orig_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_copy) |-> (out_addr == $past(in_addr)) && $past(in_valid));

   // R3
   copy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_copy) |-> $past(out_valid && !out_copy));

   // R4
   copy_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_copy) |-> (dcm_kind_e'(out_kind) == KIND_POSTED));

   // R7
   stall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> (in_ready && out_valid && out_copy));

   // R8
   cnt_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (same_port_cnt != $past(same_port_cnt)) |-> (out_valid && out_copy));

endmodule

// File: rtl/dualcast_matcher.sv
module dualcast_matcher
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NWIN   = 4,
   parameter int PORT_W = 3,
   parameter int TAG_W  = 8,
   parameter int CNT_W  = 16,
   localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WIN_W-1:0]  cfg_win,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [PORT_W-1:0] in_port,
   output logic              out_valid,
   output logic              out_copy,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TAG_W-1:0]  out_tag,
   output logic [PORT_W-1:0] out_port,
   output logic [CNT_W-1:0]  same_port_cnt
);

   // Elaboration-time parameter checks
   if (NWIN < 1) begin : g_bad_nwin
      $error("dualcast_matcher: NWIN must be at least 1");
   end
   if (PORT_W < 1 || ADDR_W <= PORT_W + CTRL_PORT_LSB) begin : g_bad_port
      $error("dualcast_matcher: control word does not fit the data width");
   end
   if (CNT_W < 1 || TAG_W < 1) begin : g_bad_cnt
      $error("dualcast_matcher: counter and tag need at least one bit");
   end

   logic [ADDR_W-1:0] win_base  [NWIN];
   logic [ADDR_W-1:0] win_limit [NWIN];
   logic [ADDR_W-1:0] win_xlat  [NWIN];
   logic [PORT_W-1:0] win_port  [NWIN];
   logic              win_en    [NWIN];
   logic              dup_hit;
   logic [ADDR_W-1:0] dup_addr;
   logic [PORT_W-1:0] dup_port;

   dcm_window_bank #(.ADDR_W(ADDR_W), .NWIN(NWIN), .PORT_W(PORT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_win   (cfg_win),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .win_base  (win_base),
      .win_limit (win_limit),
      .win_xlat  (win_xlat),
      .win_port  (win_port),
      .win_en    (win_en)
   );

   dcm_match #(.ADDR_W(ADDR_W), .NWIN(NWIN), .PORT_W(PORT_W)) u_match (
      .addr      (in_addr),
      .kind      (in_kind),
      .win_base  (win_base),
      .win_limit (win_limit),
      .win_xlat  (win_xlat),
      .win_port  (win_port),
      .win_en    (win_en),
      .dup_hit   (dup_hit),
      .dup_addr  (dup_addr),
      .dup_port  (dup_port)
   );

   dcm_issue #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_issue (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_kind       (in_kind),
      .in_addr       (in_addr),
      .in_tag        (in_tag),
      .in_port       (in_port),
      .dup_hit       (dup_hit),
      .dup_addr      (dup_addr),
      .dup_port      (dup_port),
      .out_valid     (out_valid),
      .out_copy      (out_copy),
      .out_kind      (out_kind),
      .out_addr      (out_addr),
      .out_tag       (out_tag),
      .out_port      (out_port),
      .same_port_cnt (same_port_cnt)
   );

   // R5: a copy is only possible when some window is enabled
   // R5
   copy_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && dup_hit) |-> (win_en.or() != 1'b0));

endmodule

// File: tb/dualcast_matcher_test.sv
module dualcast_matcher_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_win = '0;
   logic [1:0]  cfg_field = '0;
   logic [63:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_kind = '0;
   logic [63:0] in_addr = '0;
   logic [7:0]  in_tag = '0;
   logic [2:0]  in_port = '0;
   logic        out_valid, out_copy;
   logic [1:0]  out_kind;
   logic [63:0] out_addr;
   logic [7:0]  out_tag;
   logic [2:0]  out_port;
   logic [15:0] same_port_cnt;

   always #2 clk = ~clk;  // 250 MHz

   dualcast_matcher uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_addr(in_addr),
      .in_tag(in_tag), .in_port(in_port),
      .out_valid(out_valid), .out_copy(out_copy), .out_kind(out_kind), .out_addr(out_addr),
      .out_tag(out_tag), .out_port(out_port), .same_port_cnt(same_port_cnt)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [63:0] mb [4], ml [4], mx [4];
   logic [2:0]  mp [4];
   logic        me [4];
   logic        m_pend;
   logic [63:0] m_caddr;
   logic [2:0]  m_cport, m_oport;
   logic        e_valid, e_copy;
   logic [1:0]  e_kind;
   logic [63:0] e_addr;
   logic [7:0]  e_tag;
   logic [2:0]  e_port;
   int          e_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            mb[i] <= '0; ml[i] <= '0; mx[i] <= '0; mp[i] <= '0; me[i] <= 1'b0;
         end
         m_pend <= 1'b0; e_valid <= 1'b0; e_copy <= 1'b0; e_cnt <= 0;
         e_kind <= '0; e_addr <= '0; e_tag <= '0; e_port <= '0;
      end else begin
         if (cfg_we) begin
            case (cfg_field)
               2'd0: mb[cfg_win] <= cfg_wdata;
               2'd1: ml[cfg_win] <= cfg_wdata;
               2'd2: mx[cfg_win] <= cfg_wdata;
               default: begin me[cfg_win] <= cfg_wdata[0]; mp[cfg_win] <= cfg_wdata[3:1]; end
            endcase
         end
         if (m_pend) begin
            m_pend  <= 1'b0;
            e_valid <= 1'b1; e_copy <= 1'b1;
            e_addr  <= m_caddr; e_port <= m_cport;
            if (m_cport == m_oport) e_cnt <= e_cnt + 1;
         end else if (in_valid) begin
            int win;
            win = -1;
            for (int i = 3; i >= 0; i--)
               if (me[i] && in_addr >= mb[i] && in_addr <= ml[i]) win = i;
            e_valid <= 1'b1; e_copy <= 1'b0;
            e_kind <= in_kind; e_addr <= in_addr; e_tag <= in_tag; e_port <= in_port;
            m_oport <= in_port;
            if (win >= 0 && in_kind == 2'd0) begin
               m_pend  <= 1'b1;
               m_caddr <= in_addr - mb[win] + mx[win];
               m_cport <= mp[win];
            end
         end else begin
            e_valid <= 1'b0; e_copy <= 1'b0;
         end
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(in_ready == !m_pend, "R7", "in_ready", 64'(in_ready), 64'(!m_pend));
         chk(out_valid == e_valid, cur_req, "out_valid", 64'(out_valid), 64'(e_valid));
         chk(same_port_cnt == 16'(e_cnt), "R8", "same_port_cnt", 64'(same_port_cnt), 64'(e_cnt));
         if (e_valid) begin
            chk(out_copy == e_copy, cur_req, "out_copy", 64'(out_copy), 64'(e_copy));
            chk(out_addr == e_addr, cur_req, "out_addr", out_addr, e_addr);
            chk(out_port == e_port, cur_req, "out_port", 64'(out_port), 64'(e_port));
            chk(out_kind == e_kind, cur_req, "out_kind", 64'(out_kind), 64'(e_kind));
            chk(out_tag == e_tag, cur_req, "out_tag", 64'(out_tag), 64'(e_tag));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cfg(input int w, input int f, input logic [63:0] d);
      cfg_we = 1'b1; cfg_win = 2'(w); cfg_field = 2'(f); cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [1:0] k, input logic [63:0] a,
                       input logic [7:0] t, input logic [2:0] p);
      bit acc;
      in_valid = 1'b1; in_kind = k; in_addr = a; in_tag = t; in_port = p;
      forever begin
         acc = in_ready;
         @(posedge clk); @(negedge clk);
         if (acc) break;
      end
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      chk(same_port_cnt == 16'd0, "R1", "counter after reset", 64'(same_port_cnt), 64'd0);

      // R1/R5: windows start disabled, so a posted write is not copied
      cur_req = "R1";
      send(2'd0, 64'h0, 8'h01, 3'd0);
      idle(2);

      // R9: program windows through field codes
      cur_req = "R9";
      cfg(0, 0, 64'h1000); cfg(0, 1, 64'h1FFF); cfg(0, 2, 64'h8000_0000); cfg(0, 3, {60'd0, 3'd5, 1'b1});
      cfg(1, 0, 64'h1800); cfg(1, 1, 64'h2FFF); cfg(1, 2, 64'h4_0000);    cfg(1, 3, {60'd0, 3'd2, 1'b1});
      cfg(2, 0, 64'hFFFF_FFFF_FFFF_F000); cfg(2, 1, 64'hFFFF_FFFF_FFFF_FFFF);
      cfg(2, 2, 64'hFFFF_FFFF_FFFF_FF00); cfg(2, 3, {60'd0, 3'd3, 1'b1});
      cfg(3, 0, 64'h5000); cfg(3, 1, 64'h5FFF); cfg(3, 2, 64'h9000); cfg(3, 3, {60'd0, 3'd1, 1'b0});

      // R3: inclusive edges and misses just outside
      cur_req = "R3";
      send(2'd0, 64'h1000, 8'h10, 3'd0); idle(2);
      send(2'd0, 64'h0FFF, 8'h11, 3'd0); idle(2);
      send(2'd0, 64'h2FFF, 8'h12, 3'd1); idle(2);
      send(2'd0, 64'h3000, 8'h13, 3'd1); idle(2);

      // R6: overlap of windows 0 and 1 -> window 0
      cur_req = "R6";
      send(2'd0, 64'h1900, 8'h20, 3'd0); idle(2);
      send(2'd0, 64'h2000, 8'h21, 3'd0); idle(2);

      // R4: non-posted and completion inside a window
      cur_req = "R4";
      send(2'd1, 64'h1000, 8'h30, 3'd0); idle(2);
      send(2'd2, 64'h1800, 8'h31, 3'd0); idle(2);

      // R5: disabled window 3
      cur_req = "R5";
      send(2'd0, 64'h5500, 8'h40, 3'd0); idle(2);

      // R7: back-to-back hits hold the input
      cur_req = "R7";
      send(2'd0, 64'h1004, 8'h50, 3'd0);
      send(2'd0, 64'h1808, 8'h51, 3'd0);
      send(2'd0, 64'h0100, 8'h52, 3'd0);
      send(2'd0, 64'h2800, 8'h53, 3'd0);
      idle(3);

      // R8: copy to the same port as the original
      cur_req = "R8";
      send(2'd0, 64'h1100, 8'h60, 3'd5); idle(2);
      chk(same_port_cnt == 16'd1, "R8", "same-port count", 64'(same_port_cnt), 64'd1);

      // R10: translation wraps modulo 2^64
      cur_req = "R10";
      send(2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 8'h70, 3'd0); idle(2);
      chk(same_port_cnt == 16'd1, "R10", "count unchanged", 64'(same_port_cnt), 64'd1);

      // R9: disable window 0 while a header is accepted on the same edge
      cur_req = "R9";
      cfg_we = 1'b1; cfg_win = 2'd0; cfg_field = 2'd3; cfg_wdata = 64'd0;
      send(2'd0, 64'h1100, 8'h80, 3'd0);
      cfg_we = 1'b0;
      idle(2);
      send(2'd0, 64'h1100, 8'h81, 3'd0); idle(2);
      cfg(0, 3, {60'd0, 3'd4, 1'b1});
      send(2'd0, 64'h1100, 8'h82, 3'd4); idle(2);
      chk(same_port_cnt == 16'd2, "R8", "same-port count final", 64'(same_port_cnt), 64'd2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule